// File: doc/BRIEF.md
# Duplex-Partitioned Serial Byte FIFO Controller

This block manages a small pool of byte storage that sits between a serial channel's shifting engine and the software-facing data path. The pool is shared by the two directions. The duplex mode decides how it is split: all of it for receive, all of it for transmit, or half for each. A single configuration write selects whether the FIFO is in use, how much of the receive side may be filled, which fill-level interrupts are enabled, and whether the controller may switch off the channel's receive or transmit enable on its own.

On the receive side the engine pushes bytes, and software pops them in arrival order. On the transmit side software pushes bytes, and the engine pops them. The receive interrupt reports that enough bytes are waiting. The transmit interrupt reports that the queue has drained to a low-water mark. When the channel runs 9-bit characters, or the FIFO is switched off, the storage is bypassed and holds nothing. With auto-disable set, the receive enable drops once every receive stage is full, and the transmit enable drops once every transmit stage is empty.

Top module: `sfifo_ctrl`

## Requirements
- R1: The 2-bit `duplex_mode` input sets the partition of the 4-byte pool: 2'b01 gives receive 4 and transmit 0, 2'b10 gives receive 0 and transmit 4, 2'b11 gives 2 each, and 2'b00 gives none. A direction whose partition is 0 accepts no pushes, and no overrun is flagged for it.
- R2: With `cfg_depth_sel`=1, the usable receive depth equals the receive level (a level of 0, or one larger than the partition, means the partition size). With 0, the whole receive partition is usable.
- R3: `rx_irq` is 1 in the cycle after the receive count is at or above the effective receive level. `tx_irq` is 1 in the cycle after the transmit count is at or below the effective transmit level.
- R4: An interrupt whose enable bit in the last configuration write was 0 never asserts.
- R5: A receive push while the receive queue holds its usable depth is dropped and sets `rx_overrun`, which stays set until the next configuration write.
- R6: A transmit pop while the transmit queue is empty gives no `tx_pop_valid` and leaves `tx_count` at 0.
- R7: Each direction returns bytes in the order they were pushed, on `*_pop_data` with `*_pop_valid` one cycle after the pop, and the two directions do not disturb each other in full duplex.
- R8: When the FIFO is disabled or `nine_bit` is 1, both counts stay 0, no push is taken, and no interrupt or overrun is raised.
- R9: A configuration write, or any change of `duplex_mode` or `nine_bit`, empties both queues in the same cycle.
- R10: With auto-disable set, `rx_en` drops one cycle after the receive shifter and buffer are full and the receive queue holds its usable depth. Pushes are ignored while `rx_en` is 0.
- R11: With auto-disable set, `tx_en` drops one cycle after the transmit queue, buffer and shifter are all empty.
- R12: After reset, counts, interrupts, overrun, pop-valid flags and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | FIFO in use |
| cfg_depth_sel | input | 1 | Limit receive depth to the receive level |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| cfg_auto_off | input | 1 | Allow automatic clearing of the enables |
| cfg_rx_lvl | input | 3 | Receive fill level |
| cfg_tx_lvl | input | 3 | Transmit low-water level |
| duplex_mode | input | 2 | Partition select (see R1) |
| nine_bit | input | 1 | Channel uses 9-bit characters (bypass) |
| rxe_req | input | 1 | Receive enable as set by software |
| txe_req | input | 1 | Transmit enable as set by software |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_shift_full | input | 1 | Receive shift register holds a byte |
| rx_buf_full | input | 1 | Receive holding buffer holds a byte |
| rx_pop | input | 1 | Software reads a received byte |
| rx_pop_data | output | 8 | Byte read from the receive queue |
| rx_pop_valid | output | 1 | `rx_pop_data` is valid |
| tx_push | input | 1 | Software writes a byte to send |
| tx_push_data | input | 8 | Byte to send |
| tx_pop | input | 1 | Transmit buffer takes a byte |
| tx_pop_data | output | 8 | Byte handed to the transmit buffer |
| tx_pop_valid | output | 1 | `tx_pop_data` is valid |
| tx_buf_empty | input | 1 | Transmit buffer is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| rx_count | output | 3 | Bytes in the receive queue |
| tx_count | output | 3 | Bytes in the transmit queue |
| rx_irq | output | 1 | Receive fill interrupt |
| tx_irq | output | 1 | Transmit low-water interrupt |
| rx_overrun | output | 1 | Sticky dropped-byte flag |
| rx_en | output | 1 | Effective receive enable |
| tx_en | output | 1 | Effective transmit enable |

## Verification
On every cycle the assertions check the following: no queue holds more than its usable depth, a flush leaves it empty, an empty pop never changes the count, the bypass states keep both queues empty, the overrun flag stays set between configuration writes, an interrupt is never seen without its enable, and `rx_en` drops after the full-receive condition. Only the bench scenarios can show which partition each duplex code produces, the exact byte order out of each region of the shared store, the interrupt thresholds at particular counts, and the transmit enable falling after the last byte leaves.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [1:0] {
    DPX_NONE = 2'b00,
    DPX_RX   = 2'b01,
    DPX_TX   = 2'b10,
    DPX_FULL = 2'b11
  } dpx_e;

  typedef struct packed {
    logic en;
    logic depth_sel;
    logic rx_ie;
    logic tx_ie;
    logic auto_off;
  } cfg_s;
endpackage

// File: rtl/sfifo_split.sv
module sfifo_split #(
  parameter int TOTAL = 4,
  parameter int CW    = 3
) (
  input  logic          active,
  input  logic [1:0]    mode,
  input  logic          depth_sel,
  input  logic [CW-1:0] rx_lvl,
  input  logic [CW-1:0] tx_lvl,
  output logic [CW-1:0] rx_part,
  output logic [CW-1:0] tx_part,
  output logic [CW-1:0] rx_cap,
  output logic [CW-1:0] rx_lvl_eff,
  output logic [CW-1:0] tx_lvl_eff
);
  import sfifo_pkg::*;

  localparam logic [CW-1:0] ALLP  = CW'(TOTAL);
  localparam logic [CW-1:0] HALFP = CW'(TOTAL / 2);

  always_comb begin
    rx_part = '0;
    tx_part = '0;
    if (active) begin
      case (dpx_e'(mode))
        DPX_RX:   rx_part = ALLP;
        DPX_TX:   tx_part = ALLP;
        DPX_FULL: begin
          rx_part = HALFP;
          tx_part = HALFP;
        end
        default: ;
      endcase
    end
    rx_lvl_eff = (rx_lvl == '0 || rx_lvl > rx_part) ? rx_part : rx_lvl;
    tx_lvl_eff = (tx_lvl == '0 || tx_lvl > tx_part) ? tx_part : tx_lvl;
    rx_cap     = depth_sel ? rx_lvl_eff : rx_part;
  end
endmodule

// File: rtl/sfifo_ring.sv
module sfifo_ring #(
  parameter int CW = 3,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] size,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok
);
  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [CW-1:0] sz);
    if (CW'(p) == sz - CW'(1)) return '0;
    return p + PW'(1);
  endfunction

  assign push_ok = push && !flush && (count < cap);
  assign pop_ok  = pop && !flush && (count != '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr, size);
      if (pop_ok)  rd_ptr <= step(rd_ptr, size);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: ;
      endcase
    end
  end

  p_depth_limit_r2: assert property (@(posedge clk) disable iff (rst)
    !flush |-> count <= cap);
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0);
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count == '0) |=> count == '0);
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int TOTAL = 4,
  parameter int DW    = 8,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [PW-1:0] waddr_a,
  input  logic [DW-1:0] wdata_a,
  input  logic          we_b,
  input  logic [PW-1:0] waddr_b,
  input  logic [DW-1:0] wdata_b,
  input  logic          re_a,
  input  logic [PW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic          re_b,
  input  logic [PW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [TOTAL];

  always_ff @(posedge clk) begin
    if (we_a) mem[waddr_a] <= wdata_a;
    if (we_b) mem[waddr_b] <= wdata_b;
  end

  always_ff @(posedge clk) begin
    if (re_a) rdata_a <= mem[raddr_a];
    if (re_b) rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
  parameter int TOTAL = 4,
  parameter int DW    = 8,
  localparam int CW   = $clog2(TOTAL + 1),
  localparam int PW   = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_en,
  input  logic          cfg_depth_sel,
  input  logic          cfg_rx_ie,
  input  logic          cfg_tx_ie,
  input  logic          cfg_auto_off,
  input  logic [CW-1:0] cfg_rx_lvl,
  input  logic [CW-1:0] cfg_tx_lvl,
  input  logic [1:0]    duplex_mode,
  input  logic          nine_bit,
  input  logic          rxe_req,
  input  logic          txe_req,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_shift_full,
  input  logic          rx_buf_full,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_pop_data,
  output logic          rx_pop_valid,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pop_data,
  output logic          tx_pop_valid,
  input  logic          tx_buf_empty,
  input  logic          tx_shift_empty,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          rx_overrun,
  output logic          rx_en,
  output logic          tx_en
);
  import sfifo_pkg::*;

  cfg_s          cfg_q;
  logic [CW-1:0] rx_lvl_q, tx_lvl_q;
  logic [1:0]    mode_q;
  logic          nine_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      rx_lvl_q <= '0;
      tx_lvl_q <= '0;
    end else if (cfg_wr) begin
      cfg_q    <= '{en: cfg_en, depth_sel: cfg_depth_sel, rx_ie: cfg_rx_ie,
                    tx_ie: cfg_tx_ie, auto_off: cfg_auto_off};
      rx_lvl_q <= cfg_rx_lvl;
      tx_lvl_q <= cfg_tx_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      nine_q <= 1'b0;
    end else begin
      mode_q <= duplex_mode;
      nine_q <= nine_bit;
    end
  end

  logic flush;
  assign flush = cfg_wr || (duplex_mode != mode_q) || (nine_bit != nine_q);

  logic [CW-1:0] rx_part, tx_part, rx_cap, rx_lvl_eff, tx_lvl_eff;

  sfifo_split #(.TOTAL(TOTAL), .CW(CW)) u_split (
    .active     (cfg_q.en && !nine_bit),
    .mode       (duplex_mode),
    .depth_sel  (cfg_q.depth_sel),
    .rx_lvl     (rx_lvl_q),
    .tx_lvl     (tx_lvl_q),
    .rx_part    (rx_part),
    .tx_part    (tx_part),
    .rx_cap     (rx_cap),
    .rx_lvl_eff (rx_lvl_eff),
    .tx_lvl_eff (tx_lvl_eff)
  );

  logic          rx_take;
  logic          rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
  logic [PW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;

  assign rx_take = rx_push && rx_en;

  sfifo_ring #(.CW(CW), .PW(PW)) u_rx_ring (
    .clk(clk), .rst(rst), .flush(flush), .size(rx_part), .cap(rx_cap),
    .push(rx_take), .pop(rx_pop), .wr_ptr(rx_wp), .rd_ptr(rx_rp),
    .count(rx_count), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  sfifo_ring #(.CW(CW), .PW(PW)) u_tx_ring (
    .clk(clk), .rst(rst), .flush(flush), .size(tx_part), .cap(tx_part),
    .push(tx_push), .pop(tx_pop), .wr_ptr(tx_wp), .rd_ptr(tx_rp),
    .count(tx_count), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  // Transmit region sits directly above the receive region
  logic [PW-1:0] tx_waddr, tx_raddr;
  assign tx_waddr = PW'(rx_part + CW'(tx_wp));
  assign tx_raddr = PW'(rx_part + CW'(tx_rp));

  sfifo_store #(.TOTAL(TOTAL), .DW(DW), .PW(PW)) u_store (
    .clk(clk),
    .we_a(rx_push_ok), .waddr_a(rx_wp),    .wdata_a(rx_push_data),
    .we_b(tx_push_ok), .waddr_b(tx_waddr), .wdata_b(tx_push_data),
    .re_a(rx_pop_ok),  .raddr_a(rx_rp),    .rdata_a(rx_pop_data),
    .re_b(tx_pop_ok),  .raddr_b(tx_raddr), .rdata_b(tx_pop_data)
  );

  // Pop strobes, interrupts and overrun
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_pop_valid <= 1'b0;
      tx_pop_valid <= 1'b0;
      rx_irq       <= 1'b0;
      tx_irq       <= 1'b0;
      rx_overrun   <= 1'b0;
    end else begin
      rx_pop_valid <= rx_pop_ok;
      tx_pop_valid <= tx_pop_ok;
      rx_irq <= !flush && cfg_q.rx_ie && (rx_part != '0) && (rx_count >= rx_lvl_eff);
      tx_irq <= !flush && cfg_q.tx_ie && (tx_part != '0) && (tx_count <= tx_lvl_eff);
      if (cfg_wr)
        rx_overrun <= 1'b0;
      else if (rx_take && !flush && (rx_part != '0) && !rx_push_ok)
        rx_overrun <= 1'b1;
    end
  end

  // Automatic clearing of the channel enables
  logic rx_stop, tx_stop, rx_off, tx_off, rx_off_nx, tx_off_nx;

  assign rx_stop = cfg_q.auto_off && (rx_part != '0) && rx_shift_full && rx_buf_full
                   && (rx_count == rx_cap);
  assign tx_stop = cfg_q.auto_off && (tx_part != '0) && tx_buf_empty && tx_shift_empty
                   && (tx_count == '0);
  assign rx_off_nx = rxe_req && !cfg_wr && (rx_off || rx_stop);
  assign tx_off_nx = txe_req && !cfg_wr && (tx_off || tx_stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_off <= 1'b0;
      tx_off <= 1'b0;
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
    end else begin
      rx_off <= rx_off_nx;
      tx_off <= tx_off_nx;
      rx_en  <= rxe_req && !rx_off_nx;
      tx_en  <= txe_req && !tx_off_nx;
    end
  end

  p_rx_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(cfg_q.rx_ie));
  p_tx_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> $past(cfg_q.tx_ie));
  p_overrun_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !cfg_wr) |=> rx_overrun);
  p_bypass_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.en || nine_bit) |=> (rx_count == '0 && tx_count == '0));
  p_auto_rx_off_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_stop && !cfg_wr) |=> !rx_en);
  p_rx_irq_level_r3: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(rx_count) != '0);
endmodule

// File: tb/sim_sfifo_ctrl.sv
module sim_sfifo_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       cfg_wr = 0, cfg_en = 0, cfg_depth_sel = 0, cfg_rx_ie = 0, cfg_tx_ie = 0, cfg_auto_off = 0;
  logic [2:0] cfg_rx_lvl = 0, cfg_tx_lvl = 0;
  logic [1:0] duplex_mode = 0;
  logic       nine_bit = 0, rxe_req = 0, txe_req = 0;
  logic       rx_push = 0, rx_shift_full = 0, rx_buf_full = 0, rx_pop = 0;
  logic [7:0] rx_push_data = 0, tx_push_data = 0;
  logic       tx_push = 0, tx_pop = 0, tx_buf_empty = 0, tx_shift_empty = 0;
  logic [7:0] rx_pop_data, tx_pop_data;
  logic       rx_pop_valid, tx_pop_valid, rx_irq, tx_irq, rx_overrun, rx_en, tx_en;
  logic [2:0] rx_count, tx_count;

  sfifo_ctrl u0 (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FIFO check FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input logic en, input logic [1:0] m, input logic ds,
                           input logic rie, input logic tie, input logic ao,
                           input logic [2:0] rl, input logic [2:0] tl);
    @(negedge clk);
    cfg_en = en; duplex_mode = m; cfg_depth_sel = ds; cfg_rx_ie = rie;
    cfg_tx_ie = tie; cfg_auto_off = ao; cfg_rx_lvl = rl; cfg_tx_lvl = tl; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    @(negedge clk);
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_push = 1; rx_push_data = d;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_push = 1; tx_push_data = d;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_rx(input string tag, input int exp);
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
    chk(tag, rx_pop_valid, 1);
    chk(tag, rx_pop_data, exp);
  endtask

  task automatic pop_tx(input string tag, input int exp);
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
    chk(tag, tx_pop_valid, 1);
    chk(tag, tx_pop_data, exp);
  endtask

  task automatic t_reset;
    chk("R12 rx_count", rx_count, 0);
    chk("R12 tx_count", tx_count, 0);
    chk("R12 irqs", {rx_irq, tx_irq}, 0);
    chk("R12 overrun", rx_overrun, 0);
    chk("R12 enables", {rx_en, tx_en}, 0);
    chk("R12 valids", {rx_pop_valid, tx_pop_valid}, 0);
  endtask

  task automatic t_half_rx;
    configure(1, 2'b01, 0, 1, 0, 0, 3'd2, 3'd0);
    push_rx(8'hA1); @(negedge clk);
    chk("R3 rx_irq below level", rx_irq, 0);
    push_rx(8'hB2); @(negedge clk);
    chk("R3 rx_irq at level", rx_irq, 1);
    push_rx(8'hC3); push_rx(8'hD4);
    chk("R1 rx depth 4", rx_count, 4);
    chk("R5 no overrun yet", rx_overrun, 0);
    push_rx(8'hE5);
    chk("R5 full push dropped", rx_count, 4);
    chk("R5 overrun set", rx_overrun, 1);
    repeat (3) @(negedge clk);
    chk("R5 overrun sticky", rx_overrun, 1);
    pop_rx("R7 rx order 1", 8'hA1);
    pop_rx("R7 rx order 2", 8'hB2);
    pop_rx("R7 rx order 3", 8'hC3);
    pop_rx("R7 rx order 4", 8'hD4);
    configure(1, 2'b01, 0, 1, 0, 0, 3'd2, 3'd0);
    chk("R5 overrun cleared by config", rx_overrun, 0);
  endtask

  task automatic t_depth_sel;
    configure(1, 2'b01, 1, 0, 0, 0, 3'd3, 3'd0);
    for (int i = 0; i < 4; i++) push_rx(8'h10 + 8'(i));
    chk("R2 limited rx depth", rx_count, 3);
    chk("R2 overrun at limit", rx_overrun, 1);
  endtask

  task automatic t_irq_enable;
    configure(1, 2'b11, 0, 0, 0, 0, 3'd1, 3'd1);
    push_rx(8'h55); @(negedge clk);
    chk("R4 rx_irq masked", rx_irq, 0);
    chk("R4 tx_irq masked", tx_irq, 0);
  endtask

  task automatic t_full_duplex;
    configure(1, 2'b11, 0, 0, 1, 0, 3'd1, 3'd1);
    @(negedge clk);
    chk("R3 tx_irq when empty", tx_irq, 1);
    push_tx(8'h31); push_tx(8'h32); push_tx(8'h33);
    chk("R1 tx half depth", tx_count, 2);
    @(negedge clk);
    chk("R3 tx_irq above level", tx_irq, 0);
    push_rx(8'h41); push_rx(8'h42); push_rx(8'h43);
    chk("R1 rx half depth", rx_count, 2);
    chk("R1 rx half overrun", rx_overrun, 1);
    chk("R7 tx untouched by rx", tx_count, 2);
    pop_tx("R7 tx order 1", 8'h31);
    pop_rx("R7 rx order dup 1", 8'h41);
    pop_tx("R7 tx order 2", 8'h32);
    pop_rx("R7 rx order dup 2", 8'h42);
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
    chk("R6 empty pop no valid", tx_pop_valid, 0);
    chk("R6 empty pop count", tx_count, 0);
  endtask

  task automatic t_half_tx_flush;
    configure(1, 2'b10, 0, 0, 0, 0, 3'd1, 3'd1);
    for (int i = 0; i < 4; i++) push_tx(8'h60 + 8'(i));
    chk("R1 tx depth 4", tx_count, 4);
    push_rx(8'h77);
    chk("R1 rx has no room", rx_count, 0);
    chk("R1 no overrun without partition", rx_overrun, 0);
    @(negedge clk); duplex_mode = 2'b01;
    @(negedge clk);
    chk("R9 mode change flush", tx_count, 0);
    configure(1, 2'b01, 0, 0, 0, 0, 3'd1, 3'd1);
    push_rx(8'h01); push_rx(8'h02);
    chk("R9 pre-flush count", rx_count, 2);
    configure(1, 2'b01, 0, 0, 0, 0, 3'd1, 3'd1);
    chk("R9 config write flush", rx_count, 0);
  endtask

  task automatic t_bypass;
    @(negedge clk); nine_bit = 1;
    configure(1, 2'b01, 0, 1, 1, 0, 3'd1, 3'd1);
    push_rx(8'h99); @(negedge clk);
    chk("R8 nine-bit rx_count", rx_count, 0);
    chk("R8 nine-bit irq", {rx_irq, tx_irq}, 0);
    chk("R8 nine-bit overrun", rx_overrun, 0);
    @(negedge clk); nine_bit = 0;
    configure(0, 2'b11, 0, 1, 1, 0, 3'd1, 3'd1);
    push_rx(8'h9A); push_tx(8'h9B); @(negedge clk);
    chk("R8 disabled counts", {rx_count, tx_count}, 0);
    chk("R8 disabled irq", {rx_irq, tx_irq}, 0);
  endtask

  task automatic t_auto_rx;
    configure(1, 2'b01, 0, 0, 0, 1, 3'd4, 3'd1);
    for (int i = 0; i < 4; i++) push_rx(8'h20 + 8'(i));
    chk("R10 rx_en before", rx_en, 1);
    @(negedge clk); rx_shift_full = 1; rx_buf_full = 1;
    @(negedge clk);
    chk("R10 rx_en auto cleared", rx_en, 0);
    push_rx(8'h2F);
    chk("R10 push ignored", rx_count, 4);
    chk("R10 no overrun while off", rx_overrun, 0);
    @(negedge clk); rx_shift_full = 0; rx_buf_full = 0; rxe_req = 0;
    @(negedge clk); rxe_req = 1;
  endtask

  task automatic t_auto_tx;
    configure(1, 2'b10, 0, 0, 0, 1, 3'd1, 3'd1);
    push_tx(8'h5C);
    @(negedge clk); tx_buf_empty = 1; tx_shift_empty = 1; txe_req = 1;
    @(negedge clk);
    chk("R11 tx_en while data", tx_en, 1);
    pop_tx("R11 last byte", 8'h5C);
    @(negedge clk);
    chk("R11 tx_en auto cleared", tx_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    rxe_req = 1;
    t_half_rx();
    t_depth_sel();
    t_irq_enable();
    t_full_duplex();
    t_half_tx_flush();
    t_bypass();
    t_auto_rx();
    t_auto_tx();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("Watchdog FAIL all: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule